// File: doc/BRIEF.md
# Compressed Min-Sum Check Node

This block is one check node of a fully parallel belief-propagation decoder. Each of its `DEGREE` neighbouring bit nodes hands it a signed message in sign-magnitude form. Instead of returning one message per edge, the node reduces all of them to a short summary. The summary holds the smallest magnitude, the runner-up magnitude, the lane that carried the smallest, and a sign parity. The bit nodes later rebuild their own per-edge result from this summary. For the edge that supplied the minimum they use the runner-up. For every edge they flip the sign by the parity and by their own sign.

The measured syndrome bit of the check is folded into the parity. A flipped syndrome therefore inverts every rebuilt sign. The same folded value is also brought out as a flag that says whether the check is currently unsatisfied by the signs it sees. The node fills the check half of a two-cycle decode round. Its summary registers on the clock edge at which the stage enable is high and holds otherwise.

Top module: `chk_node_compress`

## Requirements
- R1: Lane k of `msg_i` occupies bits [k*(MAG_W+1) +: MAG_W+1]. Its top bit is the sign (1 = negative) and its low MAG_W bits are an unsigned magnitude.
- R2: After a capture, `min1_o` is the smallest of the DEGREE lane magnitudes and `min2_o` is the smallest magnitude among the remaining lanes, so `min1_o` <= `min2_o`.
- R3: After a capture, `min_idx_o` is the lowest lane number whose magnitude equals `min1_o`.
- R4: When two or more lanes share the smallest magnitude, `min2_o` equals `min1_o`.
- R5: After a capture, `parity_o` is the XOR of all DEGREE sign bits and `syndrome_i`.
- R6: After a capture, `unsat_o` is 1 exactly when the XOR of the sign bits differs from `syndrome_i`.
- R7: The outputs take the values computed from the inputs present at a rising clock edge with `stage_en_i` high. They change at that edge and not before it.
- R8: At a rising edge with `stage_en_i` low, all outputs keep their values, whatever the message and syndrome inputs do.
- R9: A rising edge with `rst_n` low clears all outputs to zero, even when `stage_en_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_en_i | input | 1 | Check-stage enable; the summary registers when high |
| syndrome_i | input | 1 | Measured syndrome bit of this check |
| msg_i | input | DEGREE*(MAG_W+1) | Packed sign-magnitude messages, one lane per edge |
| min1_o | output | MAG_W | Smallest incoming magnitude |
| min2_o | output | MAG_W | Second-smallest incoming magnitude |
| min_idx_o | output | clog2(DEGREE) | Lane that carried the smallest magnitude |
| parity_o | output | 1 | Sign XOR folded with the syndrome |
| unsat_o | output | 1 | Check currently unsatisfied |

## Verification
The assertions take for granted that `stage_en_i`, `syndrome_i` and every lane of `msg_i` are known (0 or 1) at each rising edge after reset, and that DEGREE is at least 2. They also assume a capture is preceded by at least one edge out of reset, so the stored copy of the last captured message is valid. The stimulus drives all inputs on the falling edge from a fixed-seed random source, so nothing is ever undriven. It alternates full-range magnitudes with a narrow 0..3 range so that ties on the minimum come up often. It also flips the inputs while the enable is low, to test the hold behaviour.

// File: rtl/cnc_pkg.sv
// cnc_pkg: shared defaults and helpers for the compressed check node.
// Assumes: nothing; pure constants and constant functions.
package cnc_pkg;

    localparam int unsigned DEF_DEGREE = 6;
    localparam int unsigned DEF_MAG_W  = 5;

    // Smallest power of two not below n (n >= 1).
    function automatic int unsigned pow2_ceil(input int unsigned n);
        int unsigned p;
        p = 1;
        while (p < n) p = p << 1;
        return p;
    endfunction

endpackage

// File: rtl/cnc_split.sv
// cnc_split: separates each packed sign-magnitude lane into a sign bit and
// an unsigned magnitude. Assumes lane k sits at [k*(MAG_W+1) +: MAG_W+1]
// with the sign in the top bit of the lane.
module cnc_split #(
    parameter int unsigned DEGREE = cnc_pkg::DEF_DEGREE,
    parameter int unsigned MAG_W  = cnc_pkg::DEF_MAG_W
) (
    input  logic [DEGREE*(MAG_W+1)-1:0] msg_i,
    output logic [DEGREE-1:0]           sign_o,
    output logic [DEGREE*MAG_W-1:0]     mag_o
);
    localparam int unsigned LANE_W = MAG_W + 1;

    // One slice per lane: top bit to the sign vector, the rest to the magnitudes.
    for (genvar k = 0; k < DEGREE; k++) begin : g_lane
        assign sign_o[k]               = msg_i[k*LANE_W + MAG_W];
        assign mag_o[k*MAG_W +: MAG_W] = msg_i[k*LANE_W +: MAG_W];
    end

endmodule

// File: rtl/cnc_sign_parity.sv
// cnc_sign_parity: folds all lane signs and the measured syndrome into one
// parity bit. Assumes sign 1 means a negative message (bit believed 1).
module cnc_sign_parity #(
    parameter int unsigned DEGREE = cnc_pkg::DEF_DEGREE
) (
    input  logic [DEGREE-1:0] sign_i,
    input  logic              syndrome_i,
    output logic              parity_o
);
    // Reduction XOR of the signs, inverted when the syndrome is set.
    always_comb begin
        parity_o = syndrome_i;
        for (int k = 0; k < DEGREE; k++) parity_o = parity_o ^ sign_i[k];
    end

endmodule

// File: rtl/cnc_min2_merge.sv
// cnc_min2_merge: combines two partial (min1, min2, index) records into one.
// Assumes record A covers lower lane numbers than record B, so a tie on the
// minimum keeps A's index and pushes B's equal value into the second slot.
module cnc_min2_merge #(
    parameter int unsigned MAG_W = cnc_pkg::DEF_MAG_W,
    parameter int unsigned IDX_W = 3
) (
    input  logic [MAG_W-1:0] a_min1_i,
    input  logic [MAG_W-1:0] a_min2_i,
    input  logic [IDX_W-1:0] a_idx_i,
    input  logic [MAG_W-1:0] b_min1_i,
    input  logic [MAG_W-1:0] b_min2_i,
    input  logic [IDX_W-1:0] b_idx_i,
    output logic [MAG_W-1:0] min1_o,
    output logic [MAG_W-1:0] min2_o,
    output logic [IDX_W-1:0] idx_o
);
    logic b_wins;

    // B only takes the lead on a strictly smaller value.
    always_comb begin
        b_wins = (b_min1_i < a_min1_i);
        if (b_wins) begin
            min1_o = b_min1_i;
            idx_o  = b_idx_i;
            min2_o = (a_min1_i < b_min2_i) ? a_min1_i : b_min2_i;
        end else begin
            min1_o = a_min1_i;
            idx_o  = a_idx_i;
            min2_o = (b_min1_i < a_min2_i) ? b_min1_i : a_min2_i;
        end
    end

endmodule

// File: rtl/cnc_min2_tree.sv
// cnc_min2_tree: balanced two-minimum merge tree over DEGREE magnitudes.
// Assumes DEGREE >= 2. Leaves are padded up to a power of two with the
// largest magnitude at the highest lane numbers, so padding never wins.
module cnc_min2_tree #(
    parameter int unsigned DEGREE = cnc_pkg::DEF_DEGREE,
    parameter int unsigned MAG_W  = cnc_pkg::DEF_MAG_W,
    parameter int unsigned IDX_W  = $clog2(DEGREE)
) (
    input  logic [DEGREE*MAG_W-1:0] mag_i,
    output logic [MAG_W-1:0]        min1_o,
    output logic [MAG_W-1:0]        min2_o,
    output logic [IDX_W-1:0]        idx_o
);
    localparam int unsigned LEAVES = cnc_pkg::pow2_ceil(DEGREE);
    localparam int unsigned NODES  = 2 * LEAVES - 1;
    localparam logic [MAG_W-1:0] MAG_TOP = '1;

    // Heap layout: node n has children 2n+1 (lower lanes) and 2n+2.
    logic [MAG_W-1:0] n_min1 [NODES];
    logic [MAG_W-1:0] n_min2 [NODES];
    logic [IDX_W-1:0] n_idx  [NODES];

    // Leaves: real lanes carry their magnitude, padding carries the maximum.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < DEGREE) begin : g_real
            assign n_min1[LEAVES-1+i] = mag_i[i*MAG_W +: MAG_W];
        end else begin : g_pad
            assign n_min1[LEAVES-1+i] = MAG_TOP;
        end
        assign n_min2[LEAVES-1+i] = MAG_TOP;
        assign n_idx[LEAVES-1+i]  = IDX_W'(i);
    end

    // Internal nodes: one merge stage each, root at node 0.
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        cnc_min2_merge #(
            .MAG_W (MAG_W),
            .IDX_W (IDX_W)
        ) u_merge (
            .a_min1_i (n_min1[2*n+1]),
            .a_min2_i (n_min2[2*n+1]),
            .a_idx_i  (n_idx[2*n+1]),
            .b_min1_i (n_min1[2*n+2]),
            .b_min2_i (n_min2[2*n+2]),
            .b_idx_i  (n_idx[2*n+2]),
            .min1_o   (n_min1[n]),
            .min2_o   (n_min2[n]),
            .idx_o    (n_idx[n])
        );
    end

    assign min1_o = n_min1[0];
    assign min2_o = n_min2[0];
    assign idx_o  = n_idx[0];

endmodule

// File: rtl/chk_node_compress.sv
// chk_node_compress: one check node that reduces DEGREE sign-magnitude
// messages to a registered summary (min1, min2, argmin lane, folded parity)
// plus an unsatisfied flag. Assumes DEGREE >= 2; synchronous active-low reset;
// the summary registers only on edges where stage_en_i is high.
module chk_node_compress #(
    parameter int unsigned DEGREE = cnc_pkg::DEF_DEGREE,
    parameter int unsigned MAG_W  = cnc_pkg::DEF_MAG_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                stage_en_i,
    input  logic                                syndrome_i,
    input  logic [DEGREE*(MAG_W+1)-1:0]         msg_i,
    output logic [MAG_W-1:0]                    min1_o,
    output logic [MAG_W-1:0]                    min2_o,
    output logic [$clog2(DEGREE)-1:0]           min_idx_o,
    output logic                                parity_o,
    output logic                                unsat_o
);
    localparam int unsigned IDX_W = $clog2(DEGREE);

    logic [DEGREE-1:0]       sign_w;
    logic [DEGREE*MAG_W-1:0] mag_w;
    logic [MAG_W-1:0]        min1_w;
    logic [MAG_W-1:0]        min2_w;
    logic [IDX_W-1:0]        idx_w;
    logic                    parity_w;

    cnc_split #(
        .DEGREE (DEGREE),
        .MAG_W  (MAG_W)
    ) u_split (
        .msg_i  (msg_i),
        .sign_o (sign_w),
        .mag_o  (mag_w)
    );

    cnc_min2_tree #(
        .DEGREE (DEGREE),
        .MAG_W  (MAG_W),
        .IDX_W  (IDX_W)
    ) u_tree (
        .mag_i  (mag_w),
        .min1_o (min1_w),
        .min2_o (min2_w),
        .idx_o  (idx_w)
    );

    cnc_sign_parity #(
        .DEGREE (DEGREE)
    ) u_parity (
        .sign_i     (sign_w),
        .syndrome_i (syndrome_i),
        .parity_o   (parity_w)
    );

    // Summary register: cleared by reset, loaded in the check stage, else held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            min1_o    <= '0;
            min2_o    <= '0;
            min_idx_o <= '0;
            parity_o  <= 1'b0;
            unsat_o   <= 1'b0;
        end else if (stage_en_i) begin
            min1_o    <= min1_w;
            min2_o    <= min2_w;
            min_idx_o <= idx_w;
            parity_o  <= parity_w;
            unsat_o   <= parity_w;
        end
    end

endmodule

// File: rtl/cnc_checker.sv
// cnc_checker: temporal checks on chk_node_compress, bound to every instance.
// Assumes known inputs at every edge after reset and DEGREE >= 2.
module cnc_checker #(
    parameter int unsigned DEGREE = cnc_pkg::DEF_DEGREE,
    parameter int unsigned MAG_W  = cnc_pkg::DEF_MAG_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        stage_en_i,
    input logic                        syndrome_i,
    input logic [DEGREE*(MAG_W+1)-1:0] msg_i,
    input logic [MAG_W-1:0]            min1_o,
    input logic [MAG_W-1:0]            min2_o,
    input logic [$clog2(DEGREE)-1:0]   min_idx_o,
    input logic                        parity_o,
    input logic                        unsat_o
);
    localparam int unsigned LANE_W = MAG_W + 1;
    localparam int unsigned IDX_W  = $clog2(DEGREE);

    logic [DEGREE*(MAG_W+1)-1:0] msg_q;
    logic                        valid_q;
    logic [MAG_W-1:0]            sel_mag;

    // Shadow copy of the last captured message, for lane-by-lane checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_q   <= '0;
            valid_q <= 1'b0;
        end else if (stage_en_i) begin
            msg_q   <= msg_i;
            valid_q <= 1'b1;
        end
    end

    // Magnitude of the captured lane that the summary names as the minimum.
    always_comb begin
        sel_mag = '0;
        for (int k = 0; k < DEGREE; k++)
            if (min_idx_o == IDX_W'(k)) sel_mag = msg_q[k*LANE_W +: MAG_W];
    end

    p_min_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (min1_o <= min2_o));

    p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (int'(min_idx_o) < int'(DEGREE)));

    p_argmin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (sel_mag == min1_o));

    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en_i |=> (parity_o == ($past(syndrome_i) ^ $past(^msg_i[DEGREE*LANE_W-1:0] ^ ^msg_i[DEGREE*LANE_W-1:0]) ^ $past(sign_fold(msg_i)))));

    p_unsat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_en_i |=> (unsat_o == ($past(sign_fold(msg_i)) != $past(syndrome_i))));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_en_i |=> ($stable(min1_o) && $stable(min2_o) && $stable(min_idx_o)
                         && $stable(parity_o) && $stable(unsat_o)));

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (min1_o == '0 && min2_o == '0 && min_idx_o == '0
                    && !parity_o && !unsat_o));

    // XOR of the sign bits of every lane.
    function automatic logic sign_fold(input logic [DEGREE*(MAG_W+1)-1:0] m);
        logic s;
        s = 1'b0;
        for (int k = 0; k < DEGREE; k++) s = s ^ m[k*LANE_W + MAG_W];
        return s;
    endfunction

    // Lanes below the argmin exceed min1; every other lane is at least min2 (R2, R3).
    always_ff @(posedge clk) begin
        if (rst_n && valid_q) begin
            for (int k = 0; k < DEGREE; k++) begin
                if (int'(min_idx_o) > k)
                    a_lower_lane_r3: assert (msg_q[k*LANE_W +: MAG_W] > min1_o);
                if (int'(min_idx_o) != k)
                    a_other_lane_r2: assert (msg_q[k*LANE_W +: MAG_W] >= min2_o);
            end
        end
    end

endmodule

bind chk_node_compress cnc_checker #(
    .DEGREE (DEGREE),
    .MAG_W  (MAG_W)
) u_cnc_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .stage_en_i (stage_en_i),
    .syndrome_i (syndrome_i),
    .msg_i      (msg_i),
    .min1_o     (min1_o),
    .min2_o     (min2_o),
    .min_idx_o  (min_idx_o),
    .parity_o   (parity_o),
    .unsat_o    (unsat_o)
);

// File: tb/tb_chk_node_compress.sv
// tb_chk_node_compress: fixed-seed random plus directed stimulus, checked
// against a behavioural model written from the requirements.
module tb_chk_node_compress;
    localparam int DEG   = 6;
    localparam int MAG_W = 5;
    localparam int LW    = MAG_W + 1;
    localparam int DW    = DEG * LW;
    localparam int IW    = $clog2(DEG);
    localparam int MAXM  = (1 << MAG_W) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic          syn;
    logic [DW-1:0] msg;
    logic [MAG_W-1:0] min1, min2;
    logic [IW-1:0]    idx;
    logic             par, unsat;

    int checks = 0;
    int fails  = 0;
    int e_min1, e_min2, e_idx, e_par, e_uns;

    always #10 clk = ~clk;

    chk_node_compress #(.DEGREE(DEG), .MAG_W(MAG_W)) dut (
        .clk(clk), .rst_n(rst_n), .stage_en_i(en), .syndrome_i(syn),
        .msg_i(msg), .min1_o(min1), .min2_o(min2), .min_idx_o(idx),
        .parity_o(par), .unsat_o(unsat)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pack(input int m [DEG], input logic [DEG-1:0] s);
        logic [DW-1:0] v;
        v = '0;
        for (int k = 0; k < DEG; k++) begin
            v[k*LW +: MAG_W]  = MAG_W'(m[k]);
            v[k*LW + MAG_W]   = s[k];
        end
        return v;
    endfunction

    // Expected summary from R1..R6: first strict minimum, min of the rest, folded signs.
    task automatic model(input logic [DW-1:0] m, input logic s);
        int best, x;
        logic sx;
        best = 0;
        for (int k = 1; k < DEG; k++)
            if (int'(m[k*LW +: MAG_W]) < int'(m[best*LW +: MAG_W])) best = k;
        e_idx  = best;
        e_min1 = int'(m[best*LW +: MAG_W]);
        e_min2 = MAXM;
        for (int k = 0; k < DEG; k++) begin
            x = int'(m[k*LW +: MAG_W]);
            if (k != best && x < e_min2) e_min2 = x;
        end
        sx = 1'b0;
        for (int k = 0; k < DEG; k++) sx = sx ^ m[k*LW + MAG_W];
        e_par = int'(sx ^ s);
        e_uns = int'(sx != s);
    endtask

    task automatic check_all(input string tag);
        chk({"R2 ", tag}, "min1", int'(min1), e_min1);
        chk({"R2 R4 ", tag}, "min2", int'(min2), e_min2);
        chk({"R3 ", tag}, "min_idx", int'(idx), e_idx);
        chk({"R1 R5 ", tag}, "parity", int'(par), e_par);
        chk({"R6 ", tag}, "unsat", int'(unsat), e_uns);
    endtask

    // One check-stage capture; R7: no change before the edge, new values after it.
    task automatic capture(input logic [DW-1:0] m, input logic s, input string tag);
        int p1;
        p1 = int'(min1);
        @(negedge clk);
        msg = m; syn = s; en = 1'b1;
        #1 chk({"R7 ", tag}, "min1 before edge", int'(min1), p1);
        @(negedge clk);
        en = 1'b0;
        model(m, s);
        check_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        int m [DEG];
        logic [DW-1:0] rv;
        void'($urandom(32'h5eed_0042));
        rst_n = 1'b0; en = 1'b1; syn = 1'b1; msg = '1;
        repeat (3) @(negedge clk);
        // R9: reset wins over an active enable.
        chk("R9", "min1 reset", int'(min1), 0);
        chk("R9", "min2 reset", int'(min2), 0);
        chk("R9", "idx reset", int'(idx), 0);
        chk("R9", "parity reset", int'(par), 0);
        chk("R9", "unsat reset", int'(unsat), 0);
        en = 1'b0; rst_n = 1'b1;
        @(negedge clk);

        m = '{9, 4, 17, 30, 12, 6};
        capture(pack(m, 6'b000001), 1'b0, "distinct");
        m = '{7, 7, 7, 7, 7, 7};
        capture(pack(m, 6'b000011), 1'b1, "all equal");
        m = '{20, 15, 3, 11, 3, 8};
        capture(pack(m, 6'b101010), 1'b0, "tie lanes 2 and 4");
        m = '{MAXM, MAXM, MAXM, MAXM, MAXM, MAXM};
        capture(pack(m, 6'b111111), 1'b1, "all maximum");
        m = '{0, 0, 0, 0, 0, 0};
        capture(pack(m, 6'b000000), 1'b1, "all zero syndrome set");
        m = '{25, 24, 23, 22, 21, 2};
        capture(pack(m, 6'b100000), 1'b1, "min on last lane");
        m = '{MAXM, MAXM, MAXM, MAXM, MAXM, MAXM - 1};
        capture(pack(m, 6'b010000), 1'b0, "near maximum");

        // R8: inputs move while the enable is low; outputs keep the last summary.
        @(negedge clk);
        msg = '0; syn = 1'b1; en = 1'b0;
        @(negedge clk);
        msg = '1;
        @(negedge clk);
        check_all("R8 hold");

        // R9 mid-run reset with enable high.
        m = '{5, 9, 1, 14, 3, 2};
        capture(pack(m, 6'b000111), 1'b1, "pre reset");
        @(negedge clk);
        rst_n = 1'b0; en = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; en = 1'b0;
        chk("R9", "min1 mid reset", int'(min1), 0);
        chk("R9", "idx mid reset", int'(idx), 0);
        chk("R9", "unsat mid reset", int'(unsat), 0);

        for (int t = 0; t < 400; t++) begin
            rv = '0;
            for (int k = 0; k < DEG; k++) begin
                rv[k*LW +: MAG_W] = MAG_W'((t % 2 == 0) ? $urandom_range(0, MAXM)
                                                        : $urandom_range(0, 3));
                rv[k*LW + MAG_W]  = 1'($urandom_range(0, 1));
            end
            capture(rv, 1'($urandom_range(0, 1)), "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule